// File: doc/BRIEF.md
# Keyed Write-Guard for Clock-Control Registers

This block sits behind a register-write bus (address, data, write strobe, channel select) and keeps a small set of clock-control registers from being changed by accident. A single global lock flag guards them. The flag changes state only when a fixed four-byte key is written, one byte per write, to a dedicated key address. The same key both opens and closes the guard. Each complete key sequence flips the lock.

Each of the two channels owns one guarded control register. Bits 7 and 6 of that register drive three per-channel enables:
- a forced-on enable for the filter-processing clock,
- a hold-on enable for the transmit audio path,
- a "coefficients may be loaded" indication.

The expected use has several steps. Firmware writes the key to open the guard. It then writes 0x80 to each channel's control register, which stops the synthesis clock. It loads filter coefficients at addresses 33 to 52, sets each control register to 0xC0, and writes the key again to close the guard. A control-register write made while the guard is closed is dropped with no indication.

Top module: `preg_guard_top`

## Requirements
- R1: After reset the guard is closed (`unlocked` = 0), both control registers read 0x00, and all per-channel enables are 0.
- R2: Four accepted writes to key address 87 carrying 0x2, 0x6, 0xC and 0x0 in that order open a closed guard. `unlocked` reads 1 after the clock edge of the fourth write.
- R3: The same four-byte key entered while the guard is open closes it again.
- R4: While the guard is closed, a write to control address 124 is discarded, and neither channel's control register changes.
- R5: While the guard is open, a write to address 124 loads `wrData` into the control register of the channel selected by `wrChan` (0 = channel A, 1 = channel B). The other channel's register is unchanged. Channel A occupies bits 7:0 of `ctlRegOut` and channel B occupies bits 15:8.
- R6: A key-address write whose data does not match the expected next key byte restarts the matcher. If that data equals 0x2, the matcher counts it as the first key byte. Otherwise it returns to waiting for the first byte.
- R7: Writes to addresses other than 87, including the coefficient range 33 to 52, leave a partly entered key and the lock state untouched.
- R8: For each channel, the enables decode as follows:
  - `filtClkOn` equals control bit 6.
  - `txPathOn` equals bit 7 AND bit 6.
  - `coefLoadEn` equals bit 7 AND NOT bit 6.

  So 0xC0 gives 1/1/0, 0x80 gives 0/0/1, and 0x00 gives 0/0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle high |
| wrAddr | input | 8 | Write address |
| wrData | input | 8 | Write data |
| wrChan | input | 1 | Channel selected for a control-register write |
| unlocked | output | 1 | 1 while the guard is open |
| ctlRegOut | output | 16 | Both control registers, channel A in the low byte |
| filtClkOn | output | 2 | Per-channel forced-on filter clock enable |
| txPathOn | output | 2 | Per-channel transmit path hold enable |
| coefLoadEn | output | 2 | Per-channel coefficient-load window indication |

## Verification
The bench writes the key while the guard is open and checks that it closes. A design that only opens the guard would stay open, so guarded writes would keep landing. The bench also enters a key split by twenty coefficient writes. A matcher that resets on foreign addresses would miss the toggle. A wrong byte in the middle of the key is sent as 0x2, which must count as a fresh first byte. A matcher that always restarts from zero would leave the guard closed. Channel isolation and writes dropped while closed are observed on the packed register output, where a broken channel decode or a missing lock check shows up as a changed byte.

// File: rtl/preg_guard_pkg.sv
package preg_guard_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int KEY_LEN  = 4;
  localparam int STEP_W   = $clog2(KEY_LEN);
  localparam int KEY_ADDR = 87;
  localparam int CTL_ADDR = 124;
  localparam int GATE_BIT = 7;
  localparam int FORCE_BIT = 6;

  // key bytes in the order they must arrive
  function automatic logic [DATA_W-1:0] keyByte(input logic [STEP_W-1:0] idx);
    case (idx)
      STEP_W'(0): keyByte = DATA_W'(8'h02);
      STEP_W'(1): keyByte = DATA_W'(8'h06);
      STEP_W'(2): keyByte = DATA_W'(8'h0C);
      default:    keyByte = DATA_W'(8'h00);
    endcase
  endfunction

  // strobes from the guard control toward the register datapath
  typedef struct packed {
    logic              ctlWr;
    logic [CH_W-1:0]   ctlChan;
    logic [DATA_W-1:0] ctlData;
  } ctl_stb_t;
endpackage

// File: rtl/preg_lock_ctrl.sv
module preg_lock_ctrl
  import preg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CH_W-1:0]   wrChan,
  output logic              unlocked,
  output ctl_stb_t          stb
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] keyStep;
  logic              unlockedQ;
  logic              keyHit;
  logic              keyMatch;
  logic              keyRestart;

  assign keyHit     = wrEn && (wrAddr == ADDR_W'(KEY_ADDR));
  assign keyMatch   = (wrData == keyByte(keyStep));
  assign keyRestart = (wrData == keyByte(STEP_W'(0)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStep   <= '0;
      unlockedQ <= 1'b0;
    end else if (keyHit) begin
      if (keyMatch) begin
        if (keyStep == LAST_STEP) begin
          keyStep   <= '0;
          unlockedQ <= ~unlockedQ;
        end else begin
          keyStep <= keyStep + STEP_W'(1);
        end
      end else begin
        keyStep <= keyRestart ? STEP_W'(1) : STEP_W'(0);
      end
    end
  end

  assign unlocked    = unlockedQ;
  assign stb.ctlWr   = wrEn && (wrAddr == ADDR_W'(CTL_ADDR)) && unlockedQ;
  assign stb.ctlChan = wrChan;
  assign stb.ctlData = wrData;

  // R7: non-key traffic leaves matcher progress alone
  p_step_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !keyHit |=> $stable(keyStep));
  // R7: lock only moves on key-address writes
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !keyHit |=> $stable(unlockedQ));
  // R2/R3: final correct byte flips the lock
  p_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (keyHit && keyMatch && keyStep == LAST_STEP) |=> (unlockedQ != $past(unlockedQ)));
  // R6: a wrong byte equal to the first key byte lands on step one
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (keyHit && !keyMatch && keyRestart) |=> (keyStep == STEP_W'(1)));
endmodule

// File: rtl/preg_ctl_datapath.sv
module preg_ctl_datapath
  import preg_guard_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_stb_t                 stb,
  output logic [NUM_CH*DATA_W-1:0] ctlRegOut,
  output logic [NUM_CH-1:0]        filtClkOn,
  output logic [NUM_CH-1:0]        txPathOn,
  output logic [NUM_CH-1:0]        coefLoadEn
);
  logic [DATA_W-1:0] ctlQ [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic selHere;
    assign selHere = stb.ctlWr && (stb.ctlChan == CH_W'(ch));

    always_ff @(posedge clk) begin
      if (!rstN)        ctlQ[ch] <= '0;
      else if (selHere) ctlQ[ch] <= stb.ctlData;
    end

    assign ctlRegOut[ch*DATA_W +: DATA_W] = ctlQ[ch];
    assign filtClkOn[ch]  = ctlQ[ch][FORCE_BIT];
    assign txPathOn[ch]   = ctlQ[ch][GATE_BIT] & ctlQ[ch][FORCE_BIT];
    assign coefLoadEn[ch] = ctlQ[ch][GATE_BIT] & ~ctlQ[ch][FORCE_BIT];

    // R5: a write aimed at another channel leaves this one alone
    p_chan_iso_r5: assert property (@(posedge clk) disable iff (!rstN)
      (stb.ctlWr && stb.ctlChan != CH_W'(ch)) |=> $stable(ctlQ[ch]));
  end
endmodule

// File: rtl/preg_guard_top.sv
module preg_guard_top
  import preg_guard_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [CH_W-1:0]          wrChan,
  output logic                     unlocked,
  output logic [NUM_CH*DATA_W-1:0] ctlRegOut,
  output logic [NUM_CH-1:0]        filtClkOn,
  output logic [NUM_CH-1:0]        txPathOn,
  output logic [NUM_CH-1:0]        coefLoadEn
);
  ctl_stb_t stb;

  preg_lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrChan(wrChan), .unlocked(unlocked), .stb(stb)
  );

  preg_ctl_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlRegOut(ctlRegOut),
    .filtClkOn(filtClkOn), .txPathOn(txPathOn), .coefLoadEn(coefLoadEn)
  );

  // R4: guarded register frozen when written while closed
  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(CTL_ADDR) && !unlocked) |=> $stable(ctlRegOut));
  // R1: reset leaves guard closed and registers cleared
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (!unlocked && ctlRegOut == '0));
endmodule

// File: tb/preg_guard_tb.sv
`timescale 1ns/1ps
module preg_guard_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [0:0]  wrChan = '0;
  logic        unlocked;
  logic [15:0] ctlRegOut;
  logic [1:0]  filtClkOn, txPathOn, coefLoadEn;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  preg_guard_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrChan(wrChan), .unlocked(unlocked), .ctlRegOut(ctlRegOut),
    .filtClkOn(filtClkOn), .txPathOn(txPathOn), .coefLoadEn(coefLoadEn)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrChan = c;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic keySeq();
    wr(8'd87, 8'h02, 1'b0);
    wr(8'd87, 8'h06, 1'b0);
    wr(8'd87, 8'h0C, 1'b0);
    wr(8'd87, 8'h00, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 unlocked", {15'd0, unlocked}, 16'd0);
    chk("R1 ctlRegOut", ctlRegOut, 16'h0000);
    chk("R1 enables", {10'd0, filtClkOn, txPathOn, coefLoadEn}, 16'd0);
  endtask

  task automatic t_locked_drop();
    wr(8'd124, 8'hC0, 1'b0);
    wr(8'd124, 8'h80, 1'b1);
    chk("R4 closed write dropped", ctlRegOut, 16'h0000);
  endtask

  task automatic t_unlock();
    keySeq();
    chk("R2 key opens", {15'd0, unlocked}, 16'd1);
  endtask

  task automatic t_chan_writes();
    wr(8'd124, 8'h80, 1'b0);
    chk("R5 chan A load", ctlRegOut, 16'h0080);
    chk("R8 0x80 decode", {10'd0, filtClkOn, txPathOn, coefLoadEn}, 16'b00_00_01);
    wr(8'd124, 8'hC0, 1'b1);
    chk("R5 chan B load, A kept", ctlRegOut, 16'hC080);
    chk("R8 0xC0 decode", {10'd0, filtClkOn, txPathOn, coefLoadEn}, 16'b10_10_01);
  endtask

  task automatic t_split_key_relock();
    wr(8'd87, 8'h02, 1'b0);
    wr(8'd87, 8'h06, 1'b0);
    for (int a = 33; a <= 52; a++) wr(8'(a), 8'(a * 3), 1'b0);
    chk("R7 coef writes keep regs", ctlRegOut, 16'hC080);
    chk("R7 still open mid key", {15'd0, unlocked}, 16'd1);
    wr(8'd87, 8'h0C, 1'b0);
    wr(8'd87, 8'h00, 1'b0);
    chk("R3 R7 split key closes", {15'd0, unlocked}, 16'd0);
    wr(8'd124, 8'h00, 1'b0);
    chk("R4 write after relock dropped", ctlRegOut, 16'hC080);
  endtask

  task automatic t_mismatch();
    wr(8'd87, 8'h02, 1'b0);
    wr(8'd87, 8'h06, 1'b0);
    wr(8'd87, 8'h05, 1'b0);
    wr(8'd87, 8'h0C, 1'b0);
    wr(8'd87, 8'h00, 1'b0);
    chk("R6 wrong byte breaks key", {15'd0, unlocked}, 16'd0);
    wr(8'd87, 8'h02, 1'b0);
    wr(8'd87, 8'h06, 1'b0);
    wr(8'd87, 8'h02, 1'b0);
    wr(8'd87, 8'h06, 1'b0);
    wr(8'd87, 8'h0C, 1'b0);
    wr(8'd87, 8'h00, 1'b0);
    chk("R6 0x2 restarts at step one", {15'd0, unlocked}, 16'd1);
  endtask

  task automatic t_final_decode();
    wr(8'd124, 8'hC0, 1'b0);
    chk("R5 chan A reload", ctlRegOut, 16'hC0C0);
    chk("R8 both 0xC0", {10'd0, filtClkOn, txPathOn, coefLoadEn}, 16'b11_11_00);
    wr(8'd124, 8'h00, 1'b1);
    chk("R8 0x00 decode chan B", {10'd0, filtClkOn, txPathOn, coefLoadEn}, 16'b01_01_00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_drop();
    t_unlock();
    t_chan_writes();
    t_split_key_relock();
    t_mismatch();
    t_final_decode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule